// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host hands it one word at a time over a valid/ready request port: a 15-bit word address, a write/read flag and, for writes, one data byte. The controller converts each request into a sequence of active-low chip-enable, write-enable and output-enable levels that meet the memory's nanosecond timing. Read results come back on a one-cycle data-valid strobe. The memory data bus is bidirectional. Here it is split into a driven byte, a sensed byte and a drive enable, which the chip's pad ring joins into a tri-state pin.

Each phase length is a parameter in clock cycles. It is derived from a nanosecond value and the clock period, rounded up, with a floor of one cycle. A read holds chip and output enable low for the access time. It captures the byte on the last cycle of that phase and then waits a float interval with the memory deselected. A write keeps output enable high throughout. It lowers write enable together with the controller's data drive, raises write enable first and then releases the drive one cycle later. Write enable only rises and falls while the address is held steady.

Back-pressure: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the host must hold its request unchanged. It is taken in the first cycle the controller is idle again. Only one request is ever in flight.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip, write and output enable are high, the data drive is off, `rd_valid` is low and `req_ready` is high.
- R2: Whenever `req_ready` is high (idle), chip enable is high, so the memory is deselected.
- R3: A read taken at edge k drives chip and output enable low with write enable high. At the 1+ACC_CYC-th cycle after k, `rd_valid` is high for exactly one cycle, and `rd_data` carries the byte stored at that address (0 if never written). ACC_CYC = ceil(35 ns / period) = 2 at 50 MHz.
- R4: In a write, chip and write enable are both low for at least PULSE_CYC consecutive cycles (1 at 50 MHz). The data drive is on with the request byte for the whole overlap, and that byte is what the memory holds afterwards.
- R5: The address bus does not change while chip enable is low.
- R6: The data drive is on only while write enable is low or in the cycle right after it rises. It is never on within FLOAT_CYC cycles (2 at 50 MHz) of a cycle in which the memory was driving (chip low, write high, output low).
- R7: The data drive is still on in the cycle where write enable rises and is off in the next cycle.
- R8: `req_ready` is low from the edge that takes a request until the last phase ends. It returns high 2+PULSE_CYC cycles after a write is taken and 1+ACC_CYC+FLOAT_CYC cycles after a read is taken. A request held during that time is taken exactly once.
- R9: Write enable is low only while chip enable is low and output enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid, one cycle |
| rd_data | output | 8 | Read byte |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Byte sensed from memory |

## Verification
A corrupted state or phase counter shows at the ports within one or two cycles. It appears as a shortened write-enable low pulse, an address move under an active chip enable, a data drive overlapping the memory's float window, or `req_ready` rising on the wrong cycle. The bench predicts, from each accepted request alone, the exact cycle where `req_ready` returns and where `rd_valid` fires. It checks every cycle against those predictions. A wrong captured byte or a lost write appears at the next read of that address. The bench reads addresses back in different orders, so such errors show up after a few transactions.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_END,
    ST_TURNAROUND
  } ctrl_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/phase_timer.sv
`timescale 1ns/1ps
module phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/rd_capture.sv
`timescale 1ns/1ps
module rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic              valid,
  output logic [DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= capture;
      if (capture) data <= din;
    end
  end
endmodule

// File: rtl/dq_drive.sv
`timescale 1ns/1ps
module dq_drive #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive_on,
  input  logic              drive_off,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      if (load) dq_out <= wdata;
      if (drive_on)       dq_oe <= 1'b1;
      else if (drive_off) dq_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int T_ACCESS_NS   = 35,
  parameter int T_WPULSE_NS   = 20,
  parameter int T_DSETUP_NS   = 15,
  parameter int T_WCYCLE_NS   = 35,
  parameter int T_FLOAT_NS    = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  import sram_ctrl_pkg::*;

  localparam int ACC_CYC   = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int FLOAT_CYC = ns_to_cyc(T_FLOAT_NS, CLK_PERIOD_NS);
  localparam int WC_CYC    = ns_to_cyc(T_WCYCLE_NS, CLK_PERIOD_NS);
  // setup and end phases take one cycle each; the pulse covers the rest
  localparam int PULSE_CYC = max2(max2(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS)),
                                  WC_CYC - 2);
  localparam int MAX_CYC   = max2(max2(ACC_CYC, FLOAT_CYC), PULSE_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1) + 1;

  ctrl_state_e       st_q, st_d;
  logic              ce_d, we_d, oe_d;
  logic [ADDR_W-1:0] addr_d;
  logic              tmr_load, tmr_last;
  logic [CNT_W-1:0]  tmr_val;
  logic              cap, wd_load, drv_on, drv_off;

  always_comb begin
    st_d     = st_q;
    ce_d     = mem_ce_n;
    we_d     = mem_we_n;
    oe_d     = mem_oe_n;
    addr_d   = mem_addr;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    wd_load  = 1'b0;
    drv_on   = 1'b0;
    drv_off  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d = req_addr;
          ce_d   = 1'b0;
          if (req_write) begin
            wd_load = 1'b1;
            st_d    = ST_WR_SETUP;
          end else begin
            oe_d     = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACC_CYC);
            st_d     = ST_RD_ACCESS;
          end
        end
      end
      ST_RD_ACCESS: begin
        if (tmr_last) begin
          cap  = 1'b1;
          ce_d = 1'b1;
          oe_d = 1'b1;
          st_d = ST_RD_CAPTURE;
        end
      end
      ST_RD_CAPTURE: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(FLOAT_CYC);
        st_d     = ST_TURNAROUND;
      end
      ST_TURNAROUND: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      ST_WR_SETUP: begin
        we_d     = 1'b0;
        drv_on   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC);
        st_d     = ST_WR_PULSE;
      end
      ST_WR_PULSE: begin
        if (tmr_last) begin
          we_d = 1'b1;
          st_d = ST_WR_END;
        end
      end
      ST_WR_END: begin
        ce_d    = 1'b1;
        drv_off = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_addr <= '0;
    end else begin
      st_q     <= st_d;
      mem_ce_n <= ce_d;
      mem_we_n <= we_d;
      mem_oe_n <= oe_d;
      mem_addr <= addr_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  rd_capture #(.DATA_W(DATA_W)) i_rdcap (
    .clk(clk), .rst(rst), .capture(cap), .din(mem_dq_in),
    .valid(rd_valid), .data(rd_data)
  );

  dq_drive #(.DATA_W(DATA_W)) i_drive (
    .clk(clk), .rst(rst), .load(wd_load), .wdata(req_wdata),
    .drive_on(drv_on), .drive_off(drv_off),
    .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid));

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n);

  p_rdvalid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_drive_in_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe);

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n || $past(!mem_we_n)));

  p_release_after_we_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe ##1 !mem_dq_oe));

  p_busy_after_take_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_we_qualified_r9: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;
  localparam int PER   = 20;
  localparam int ACC   = (35 + PER - 1) / PER;
  localparam int FLT   = (35 + PER - 1) / PER;
  localparam int PLS   = 1;
  localparam int RD_BUSY = 1 + ACC + FLT;
  localparam int WR_BUSY = 2 + PLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dq_out;
  logic [14:0] mem_addr;
  logic [7:0] dq_in_r = '0;

  always #(PER/2) clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in_r)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] mem_m [int];
  logic [7:0] gold [int];
  int exp_cyc[$];
  logic [7:0] exp_dat[$];
  int ready_due = 0;
  int last_drv = -100;
  int wr_len = 0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic we_prev = 1'b1, we_rose_prev = 1'b0;
  bit model_on = 1'b0;

  function automatic logic [7:0] rd_arr(input logic [7:0] a [int], input int k);
    return a.exists(k) ? a[k] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // behavioural memory and reference model, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (model_on) begin
      // memory array: commit a write when the CE/WE overlap ends
      if (!mem_ce_n && !mem_we_n) begin
        if (wr_len > 0) chk(mem_addr == wr_addr, "R5", mem_addr, wr_addr);
        chk(mem_dq_oe, "R4", mem_dq_oe, 1);
        wr_len++; wr_addr = mem_addr; wr_data = mem_dq_out;
      end else if (wr_len > 0) begin
        chk(wr_len >= PLS, "R4", wr_len, PLS);
        mem_m[int'(wr_addr)] = wr_data;
        wr_len = 0;
      end
      if (!mem_we_n) chk(!mem_ce_n && mem_oe_n, "R9", {mem_ce_n, mem_oe_n}, 2'b01);
      // contention against the memory's own drive and float window
      if (!mem_ce_n && mem_we_n && !mem_oe_n) last_drv = cyc;
      if (mem_dq_oe)
        chk(cyc - last_drv > FLT && (!mem_we_n || !we_prev), "R6", cyc - last_drv, FLT + 1);
      if (mem_we_n && !we_prev) chk(mem_dq_oe, "R7", mem_dq_oe, 1);
      if (we_rose_prev) chk(!mem_dq_oe, "R7", mem_dq_oe, 0);
      we_rose_prev = mem_we_n && !we_prev;
      we_prev = mem_we_n;
      dq_in_r <= (!mem_ce_n && mem_we_n && !mem_oe_n) ? rd_arr(mem_m, int'(mem_addr)) : 8'h00;
      // handshake timing
      if (req_ready) chk(mem_ce_n, "R2", mem_ce_n, 1);
      if (cyc < ready_due) chk(!req_ready, "R8", req_ready, 0);
      else if (cyc == ready_due) chk(req_ready, "R8", req_ready, 1);
      // read results
      if (rd_valid) begin
        if (exp_cyc.size() == 0) chk(0, "R3", rd_valid, 0);
        else begin
          chk(exp_cyc[0] == cyc, "R3", cyc, exp_cyc[0]);
          chk(rd_data == exp_dat[0], "R3", rd_data, exp_dat[0]);
          void'(exp_cyc.pop_front()); void'(exp_dat.pop_front());
        end
      end else if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc) begin
        chk(0, "R3", 0, 1);
        void'(exp_cyc.pop_front()); void'(exp_dat.pop_front());
      end
      // acceptance happens at the coming rising edge
      if (req_valid && req_ready) begin
        if (req_write) begin
          gold[int'(req_addr)] = req_wdata;
          ready_due = cyc + WR_BUSY + 1;
        end else begin
          exp_cyc.push_back(cyc + ACC + 1);
          exp_dat.push_back(rd_arr(gold, int'(req_addr)));
          ready_due = cyc + RD_BUSY + 1;
        end
      end
    end
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (RD_BUSY + 3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
        "R1", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
        "R1", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid, req_ready}, 6'b111001);
    model_on = 1'b1;
    // directed: boundary addresses and data patterns (R3 R4)
    issue(1, 15'h0000, 8'hA5);
    issue(1, 15'h7FFF, 8'hFF);
    issue(1, 15'h1234, 8'h00);
    issue(0, 15'h7FFF, 8'h00);
    issue(0, 15'h0000, 8'h00);
    issue(0, 15'h1234, 8'h00);
    issue(0, 15'h0555, 8'h00);   // never written: R3 expects 0
    // write then read the same word back to back, then overwrite
    issue(1, 15'h0042, 8'h3C);
    issue(0, 15'h0042, 8'h00);
    issue(1, 15'h0042, 8'hC3);
    issue(0, 15'h0042, 8'h00);
    drain();
    // random mix, small address pool, random gaps incl. zero (back-pressure R8)
    for (int i = 0; i < 150; i++) begin
      logic [14:0] a;
      a = 15'({$urandom_range(0, 3), 11'h000} | 15'($urandom_range(0, 7)));
      issue($urandom_range(0, 1) == 1, a, 8'($urandom));
      repeat ($urandom_range(0, 3)) @(posedge clk);
    end
    drain();
    chk(exp_cyc.size() == 0, "R3", exp_cyc.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule